// File: doc/BRIEF.md
# CAN Controller Status Register

This block holds the eight-bit status word of a CAN protocol controller. The protocol engine reports events to it: a frame sent or received without fault, bus activity while the controller sleeps, and the class of each error it detects. The engine also supplies the current values of its transmit and receive error counters. The block turns these inputs into sticky flags and a three-bit error-code field. It derives the warning and bus-off flags from the counters. A host read/write port exposes the word.

Each flag follows its own clear rule. The wake flag clears when the host reads the word. The transfer-success flags clear only when the host writes to them. The error-code field holds the class of the latest error until the next error or a host write replaces it. When an engine event and a host write reach the same bit in the same cycle, the event wins, so no event is lost.

Top module: `can_stat_reg`

## Requirements
- R1: While reset is low, and in the first cycle after it, every bit of `rd_data_o` is 0, provided both counters are at or below the warning limit.
- R2: `rd_data_o` always shows the current word with this layout: bit 7 bus-off, bit 6 warning, bit 5 wake, bit 4 receive-success, bit 3 transmit-success, bits 2:0 error code.
- R3: A `ev_tx_ok_i` pulse sets bit 3 from the next cycle on. Bit 3 then stays set until a host write clears it.
- R4: A `ev_rx_ok_i` pulse sets bit 4 from the next cycle on. Bit 4 then stays set until a host write clears it.
- R5: A host write loads `wr_data_i[4:0]` into bits 4:0 from the next cycle on. Bits 7:5 are not changed by a write.
- R6: If an event and a host write hit the same bit in the same cycle, the event wins. A success event leaves its bit set. An error event stores its own code, not the written code.
- R7: An `err_vld_i` pulse whose `err_kind_i` is 1 to 6 stores that code in bits 2:0. The codes are 1 stuff, 2 form, 3 acknowledge, 4 sent recessive but saw dominant, 5 sent dominant but saw recessive, and 6 CRC. Codes 0 and 7 leave the field unchanged.
- R8: Bit 5 is set in the cycle after `bus_act_i` is high while `sleep_i` is high. Activity while `sleep_i` is low has no effect.
- R9: A cycle with `rd_en_i` high returns the word unchanged and clears bit 5 from the next cycle on. A wake event in the same cycle as the read keeps bit 5 set. A read changes no other bit.
- R10: Bit 6 is high one cycle after either counter is strictly above WARN_LIMIT (default 96).
- R11: Bit 7 is high one cycle after the transmit counter is strictly above BOFF_LIMIT (default 255).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_tx_ok_i | input | 1 | Frame sent without fault (one-cycle pulse) |
| ev_rx_ok_i | input | 1 | Frame received without fault (one-cycle pulse) |
| sleep_i | input | 1 | Controller is in sleep mode |
| bus_act_i | input | 1 | Bus activity seen |
| err_vld_i | input | 1 | Error detected this cycle |
| err_kind_i | input | 3 | Class of the detected error |
| tec_i | input | CNT_W | Transmit error counter |
| rec_i | input | CNT_W | Receive error counter |
| rd_en_i | input | 1 | Host reads the status word |
| wr_en_i | input | 1 | Host writes the writable bits |
| wr_data_i | input | 5 | Write value for bits 4:0 |
| rd_data_o | output | 8 | Status word |

## Verification
The bound checker tests these rules on every cycle: setting of each success flag, hold of each flag when nothing touches it, loading on a host write, storing of valid error codes, setting and read-clearing of wake, and the strict threshold compares behind warning and bus-off. Other cases need the bench's directed scenarios. These are the exact thresholds at 96/97 and 255/256, the collision of a write with an event, codes 0 and 7 being ignored, activity while awake being ignored, and a wake event landing in the same cycle as a read.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

   // error classes reported by the protocol engine
   typedef enum logic [2:0] {
      ERRC_NONE  = 3'd0,
      ERRC_STUFF = 3'd1,
      ERRC_FORM  = 3'd2,
      ERRC_ACK   = 3'd3,
      ERRC_REC   = 3'd4,   // drove recessive, sampled dominant
      ERRC_DOM   = 3'd5,   // drove dominant, sampled recessive
      ERRC_CRC   = 3'd6,
      ERRC_RSVD  = 3'd7
   } errc_e;

   // status word, msb first: packed order is the bit layout
   typedef struct packed {
      logic  busoff;
      logic  warn;
      logic  wake;
      logic  rx_ok;
      logic  tx_ok;
      errc_e code;
   } stat_word_t;

   localparam int STAT_W = $bits(stat_word_t);
   localparam int WR_W   = 5;

   function automatic logic errc_storable(input logic [2:0] k);
      return (k != ERRC_NONE) && (k != ERRC_RSVD);
   endfunction

endpackage

// File: rtl/can_stat_limit.sv
// Strict "count above limit" compare, optionally registered.
module can_stat_limit #(
   parameter int CNT_W   = 9,
   parameter int LIMIT   = 96,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             above_o
);
   localparam logic [CNT_W-1:0] LIM = LIMIT[CNT_W-1:0];

   logic above_d;
   assign above_d = (cnt_i > LIM);

   generate
      if (REG_OUT) begin : g_reg
         logic above_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) above_q <= 1'b0;
            else         above_q <= above_d;
         end
         assign above_o = above_q;
      end else begin : g_comb
         assign above_o = above_d;
      end
   endgenerate
endmodule

// File: rtl/can_stat_flag.sv
// One sticky flag: event set beats host write, which beats read clear.
module can_stat_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic wr_i,
   input  logic wr_val_i,
   input  logic rd_clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (set_i)    flag_q <= 1'b1;
      else if (wr_i)     flag_q <= wr_val_i;
      else if (rd_clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/can_stat_errcode.sv
// Last-error-code field: a valid engine code beats a host write.
module can_stat_errcode
   import can_stat_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       err_vld_i,
   input  logic [2:0] err_kind_i,
   input  logic       wr_i,
   input  logic [2:0] wr_val_i,
   output errc_e      code_o
);
   errc_e code_q;
   logic  take_err;

   assign take_err = err_vld_i && errc_storable(err_kind_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       code_q <= ERRC_NONE;
      else if (take_err) code_q <= errc_e'(err_kind_i);
      else if (wr_i)     code_q <= errc_e'(wr_val_i);
   end

   assign code_o = code_q;
endmodule

// File: rtl/can_stat_reg.sv
module can_stat_reg
   import can_stat_pkg::*;
#(
   parameter int CNT_W      = 9,
   parameter int WARN_LIMIT = 96,
   parameter int BOFF_LIMIT = 255,
   parameter bit LIMIT_REG  = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ev_tx_ok_i,
   input  logic             ev_rx_ok_i,
   input  logic             sleep_i,
   input  logic             bus_act_i,
   input  logic             err_vld_i,
   input  logic [2:0]       err_kind_i,
   input  logic [CNT_W-1:0] tec_i,
   input  logic [CNT_W-1:0] rec_i,
   input  logic             rd_en_i,
   input  logic             wr_en_i,
   input  logic [4:0]       wr_data_i,
   output logic [7:0]       rd_data_o
);
   localparam int NCNT    = 2;
   localparam int CNT_TOP = (1 << CNT_W) - 1;

   initial begin
      assert (CNT_W >= 2 && CNT_W <= 16)
         else $fatal(1, "can_stat_reg: CNT_W out of range");
      assert (WARN_LIMIT >= 0 && WARN_LIMIT < BOFF_LIMIT)
         else $fatal(1, "can_stat_reg: WARN_LIMIT must be below BOFF_LIMIT");
      assert (BOFF_LIMIT < CNT_TOP)
         else $fatal(1, "can_stat_reg: BOFF_LIMIT needs a wider counter");
      assert (STAT_W == 8 && WR_W == 5)
         else $fatal(1, "can_stat_reg: status layout mismatch");
   end

   stat_word_t       stat;
   logic [CNT_W-1:0] cnt_v [NCNT];
   logic [NCNT-1:0]  warn_v;
   logic             wake_evt;

   assign cnt_v[0]  = tec_i;
   assign cnt_v[1]  = rec_i;
   assign wake_evt  = sleep_i && bus_act_i;

   // warning compare per counter
   generate
      for (genvar gi = 0; gi < NCNT; gi++) begin : g_warn
         can_stat_limit #(
            .CNT_W  (CNT_W),
            .LIMIT  (WARN_LIMIT),
            .REG_OUT(LIMIT_REG)
         ) u_warn (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cnt_i  (cnt_v[gi]),
            .above_o(warn_v[gi])
         );
      end
   endgenerate

   assign stat.warn = |warn_v;

   // bus-off follows the transmit counter
   can_stat_limit #(
      .CNT_W  (CNT_W),
      .LIMIT  (BOFF_LIMIT),
      .REG_OUT(LIMIT_REG)
   ) u_boff (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (tec_i),
      .above_o(stat.busoff)
   );

   can_stat_flag u_wake (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (wake_evt),
      .wr_i    (1'b0),
      .wr_val_i(1'b0),
      .rd_clr_i(rd_en_i),
      .flag_o  (stat.wake)
   );

   can_stat_flag u_rxok (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (ev_rx_ok_i),
      .wr_i    (wr_en_i),
      .wr_val_i(wr_data_i[4]),
      .rd_clr_i(1'b0),
      .flag_o  (stat.rx_ok)
   );

   can_stat_flag u_txok (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (ev_tx_ok_i),
      .wr_i    (wr_en_i),
      .wr_val_i(wr_data_i[3]),
      .rd_clr_i(1'b0),
      .flag_o  (stat.tx_ok)
   );

   can_stat_errcode u_code (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .err_vld_i (err_vld_i),
      .err_kind_i(err_kind_i),
      .wr_i      (wr_en_i),
      .wr_val_i  (wr_data_i[2:0]),
      .code_o    (stat.code)
   );

   assign rd_data_o = stat;
endmodule

// File: rtl/can_stat_reg_chk.sv
module can_stat_reg_chk #(
   parameter int CNT_W      = 9,
   parameter int WARN_LIMIT = 96,
   parameter int BOFF_LIMIT = 255,
   parameter bit LIMIT_REG  = 1'b1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             ev_tx_ok_i,
   input logic             ev_rx_ok_i,
   input logic             sleep_i,
   input logic             bus_act_i,
   input logic             err_vld_i,
   input logic [2:0]       err_kind_i,
   input logic [CNT_W-1:0] tec_i,
   input logic [CNT_W-1:0] rec_i,
   input logic             rd_en_i,
   input logic             wr_en_i,
   input logic [4:0]       wr_data_i,
   input logic [7:0]       rd_data_o
);
   localparam logic [CNT_W-1:0] WL = WARN_LIMIT[CNT_W-1:0];
   localparam logic [CNT_W-1:0] BL = BOFF_LIMIT[CNT_W-1:0];

   logic wk;
   logic any_ev;
   assign wk     = sleep_i && bus_act_i;
   assign any_ev = ev_tx_ok_i || ev_rx_ok_i || err_vld_i;

   assert_txok_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_tx_ok_i |=> rd_data_o[3]);
   assert_txok_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ev_tx_ok_i && !wr_en_i) |=> (rd_data_o[3] == $past(rd_data_o[3])));
   assert_rxok_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_rx_ok_i |=> rd_data_o[4]);
   assert_rxok_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ev_rx_ok_i && !wr_en_i) |=> (rd_data_o[4] == $past(rd_data_o[4])));
   assert_write_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !any_ev) |=> (rd_data_o[4:0] == $past(wr_data_i)));
   assert_code_store_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_vld_i && err_kind_i != 3'd0 && err_kind_i != 3'd7)
         |=> (rd_data_o[2:0] == $past(err_kind_i)));
   assert_wake_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wk |=> rd_data_o[5]);
   assert_wake_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wk && !rd_en_i) |=> (rd_data_o[5] == $past(rd_data_o[5])));
   assert_wake_rdclr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && !wk) |=> !rd_data_o[5]);

   generate
      if (LIMIT_REG) begin : g_reg
         assert_warn_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            1'b1 |=> (rd_data_o[6] == ($past(tec_i) > WL || $past(rec_i) > WL)));
         assert_boff_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            1'b1 |=> (rd_data_o[7] == ($past(tec_i) > BL)));
      end else begin : g_comb
         assert_warn_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rd_data_o[6] == (tec_i > WL || rec_i > WL));
         assert_boff_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rd_data_o[7] == (tec_i > BL));
      end
   endgenerate
endmodule

bind can_stat_reg can_stat_reg_chk #(
   .CNT_W     (CNT_W),
   .WARN_LIMIT(WARN_LIMIT),
   .BOFF_LIMIT(BOFF_LIMIT),
   .LIMIT_REG (LIMIT_REG)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .ev_tx_ok_i(ev_tx_ok_i),
   .ev_rx_ok_i(ev_rx_ok_i),
   .sleep_i   (sleep_i),
   .bus_act_i (bus_act_i),
   .err_vld_i (err_vld_i),
   .err_kind_i(err_kind_i),
   .tec_i     (tec_i),
   .rec_i     (rec_i),
   .rd_en_i   (rd_en_i),
   .wr_en_i   (wr_en_i),
   .wr_data_i (wr_data_i),
   .rd_data_o (rd_data_o)
);

// File: tb/can_stat_reg_tb_top.sv
module can_stat_reg_tb_top;
   localparam int CNT_W = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ev_tx = 1'b0, ev_rx = 1'b0, sleep = 1'b0, act = 1'b0;
   logic             err_vld = 1'b0;
   logic [2:0]       err_kind = 3'd0;
   logic [CNT_W-1:0] tec = '0, rec = '0;
   logic             rd_en = 1'b0, wr_en = 1'b0;
   logic [4:0]       wr_data = '0;
   logic [7:0]       rd_data;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #4 clk = ~clk;   // 125 MHz

   can_stat_reg dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .ev_tx_ok_i(ev_tx), .ev_rx_ok_i(ev_rx),
      .sleep_i(sleep), .bus_act_i(act),
      .err_vld_i(err_vld), .err_kind_i(err_kind),
      .tec_i(tec), .rec_i(rec),
      .rd_en_i(rd_en), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .rd_data_o(rd_data)
   );

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         n_bad++;
         $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, got, exp);
      end
   endtask

   // one clock: inputs set before, cleared after the edge, sample at negedge
   task automatic step();
      @(negedge clk);
      ev_tx = 0; ev_rx = 0; act = 0; err_vld = 0; rd_en = 0; wr_en = 0;
   endtask

   task automatic host_wr(input logic [4:0] v);
      wr_en = 1; wr_data = v; step();
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 in reset", rd_data, 8'h00);
      rst_n = 1;
      @(negedge clk);
      chk("R1 after reset", rd_data, 8'h00);
   endtask

   task automatic t_txrx();
      ev_tx = 1; step();
      chk("R3 tx set", rd_data, 8'h08);
      repeat (3) step();
      chk("R3 tx sticky", rd_data, 8'h08);
      ev_rx = 1; step();
      chk("R4 rx set, R2 layout", rd_data, 8'h18);
      rd_en = 1; #1;
      chk("R9 read value", rd_data, 8'h18);
      step();
      chk("R9 read keeps ok bits", rd_data, 8'h18);
   endtask

   task automatic t_write();
      host_wr(5'b00000);
      chk("R5 write clears", rd_data, 8'h00);
      host_wr(5'b11101);
      chk("R5 write loads", rd_data, 8'h1D);
      host_wr(5'b01011);
      chk("R5 write loads", rd_data, 8'h0B);
      host_wr(5'b11000);
   endtask

   task automatic t_code();
      for (int k = 1; k <= 6; k++) begin
         err_vld = 1; err_kind = 3'(k); step();
         chk($sformatf("R7 code %0d", k), rd_data, 8'h18 | 8'(k));
      end
      err_vld = 1; err_kind = 3'd0; step();
      chk("R7 code 0 ignored", rd_data, 8'h1E);
      err_vld = 1; err_kind = 3'd7; step();
      chk("R7 code 7 ignored", rd_data, 8'h1E);
   endtask

   task automatic t_collide();
      wr_en = 1; wr_data = 5'b10010; ev_tx = 1; step();
      chk("R6 tx event beats write", rd_data, 8'h1A);
      wr_en = 1; wr_data = 5'b00001; err_vld = 1; err_kind = 3'd5; step();
      chk("R6 error code beats write", rd_data, 8'h05);
      wr_en = 1; wr_data = 5'b00000; ev_rx = 1; step();
      chk("R6 rx event beats write", rd_data, 8'h10);
      host_wr(5'b00000);
   endtask

   task automatic t_wake();
      act = 1; step();
      chk("R8 activity awake ignored", rd_data, 8'h00);
      sleep = 1; act = 1; step();
      chk("R8 wake set", rd_data, 8'h20);
      host_wr(5'b00000);
      chk("R5 write leaves wake", rd_data, 8'h20);
      rd_en = 1; #1;
      chk("R9 read shows wake", rd_data, 8'h20);
      step();
      chk("R9 wake cleared by read", rd_data, 8'h00);
      act = 1; rd_en = 1; step();
      chk("R9 wake set beats read", rd_data, 8'h20);
      sleep = 0; rd_en = 1; step();
      chk("R9 wake cleared", rd_data, 8'h00);
   endtask

   task automatic t_limits();
      tec = 9'd96; step();
      chk("R10 tec 96 no warn", rd_data, 8'h00);
      tec = 9'd97; step();
      chk("R10 tec 97 warn", rd_data, 8'h40);
      tec = 9'd0; rec = 9'd97; step();
      chk("R10 rec 97 warn", rd_data, 8'h40);
      rec = 9'd96; step();
      chk("R10 rec 96 no warn", rd_data, 8'h00);
      rec = 9'd0; tec = 9'd255; step();
      chk("R11 tec 255 no busoff", rd_data, 8'h40);
      tec = 9'd256; step();
      chk("R11 tec 256 busoff", rd_data, 8'hC0);
      rec = 9'd300; tec = 9'd0; step();
      chk("R11 rec alone no busoff", rd_data, 8'h40);
      rec = 9'd0; step();
      chk("R10 back below", rd_data, 8'h00);
   endtask

   initial begin
      t_reset();
      t_txrx();
      t_write();
      t_code();
      t_collide();
      t_wake();
      t_limits();
      summary();
      $finish;
   end
endmodule